// File: doc/BRIEF.md
# General-Purpose Pin Port with Blink and Change Fault

This block manages a small group of general-purpose pins. Each pin has an open-drain pull-down that a drive bit controls, a synchronized readback of its live level, an optional slow blink of the pull-down, and an optional fault that latches when the pin level moves away from a stored reference level. A serial register interface outside this block writes and reads two registers: a data register and a setup register.

The data register holds the synchronized pin levels in its upper half and the drive bits in its lower half. The setup register holds the blink enables in its upper half and the fault enables in its lower half. A drive bit of 1 releases the pull-down, so the pin can act as an input. A drive bit of 0 turns the pull-down on. When a pin's blink enable is set and its drive bit is 0, the pull-down switches on and off under a shared slow phase. A 50 kHz tick is divided to make that phase. With the default divisor, the phase toggles every 16384 ticks, giving a blink of about 1.5 Hz.

The reference level for each pin is taken when its fault enable goes from 0 to 1, and again at every fault-clear strobe. While the fault enable is set, any difference between the synchronized level and the reference latches that pin's fault. The fault clears on a fault-clear strobe or when the pin's fault enable is written to 0.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset, all drive bits read 1, the setup register reads 0x00, every fault bit is 0, and every pull-down enable is 0.
- R2: A data-register write loads wr_data[NPIN-1:0] into the drive bits, with pin i at bit i, and ignores the upper bits. The pull-down enable of pin i is 1 exactly when its drive bit is 0 and blinking does not currently switch it off. A drive bit of 1 always leaves the pull-down off.
- R3: data_rd[NPIN+i] reads the level of pin i two clock edges after it was sampled. The two-flop synchronizer resets to 1.
- R4: A setup-register write loads the blink enables from wr_data[2*NPIN-1:NPIN] (pin i at bit NPIN+i) and the fault enables from wr_data[NPIN-1:0] (pin i at bit i). setup_rd returns the stored value.
- R5: Each tick advances a shared divider. After every BLINK_DIV ticks the blink phase toggles, and the phase starts in its "on" half after reset. A pin with its blink enable set and its drive bit at 0 has its pull-down on in the "on" half and off in the other half.
- R6: A blink enable has no effect on a pin whose drive bit is 1; its pull-down stays off.
- R7: When a pin's fault enable rises, the current synchronized level is stored as that pin's reference. A later difference from the reference latches the fault, and the fault stays set if the pin returns to the reference level.
- R8: A pin whose fault enable is 0 never raises a fault, however its level changes.
- R9: A fault-clear strobe clears all fault bits and stores each pin's current level as its new reference. A later move away from that level raises the fault again; staying at that level does not.
- R10: Writing a pin's fault enable to 0 clears that pin's fault in the same cycle.
- R11: If a fault-clear strobe and a level change reach the comparison in the same cycle, the clear wins, and the new level becomes the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_50k | input | 1 | One-cycle pulse at 50 kHz that drives the blink divider |
| pin_in | input | NPIN | Raw pin levels |
| data_wr | input | 1 | Write strobe for the data register |
| setup_wr | input | 1 | Write strobe for the setup register |
| wr_data | input | 2*NPIN | Write data for either register |
| fault_clr | input | 1 | Fault-clear strobe, raised when the fault register is written |
| pull_en | output | NPIN | Pull-down enable per pin |
| data_rd | output | 2*NPIN | Data register read value: pin levels over drive bits |
| setup_rd | output | 2*NPIN | Setup register read value: blink enables over fault enables |
| fault | output | NPIN | Latched change fault per pin |

## Verification
Checked on every cycle: a released drive bit never comes with an active pull-down, both register writes land one cycle later, readback trails the pins by exactly two edges, and a fault never sits on a pin whose enable is clear. Also checked every cycle: a fault-clear empties the fault bits, and a latched fault persists unless a clear or a setup write intervenes. The bench scenarios show the behaviours that depend on history. These are the reference captured at enable and at clear, refault only after a move away from the new reference, the clear winning over a simultaneous change, and the blink phase flipping exactly at the BLINK_DIV-th tick.

// File: rtl/gpio_pkg.sv
// Shared types for the general-purpose pin port.
// Assumes nothing beyond a synthesizable packed struct.
package gpio_pkg;

    // Per-pin stored state inside a pin slice.
    typedef struct packed {
        logic drive;    // 1 = pull-down released
        logic blink;    // blink enable
        logic fen;      // change-fault enable
        logic ref_lvl;  // reference level for change detection
        logic flt;      // latched fault
    } pin_state_t;

    localparam pin_state_t PIN_RESET = '{drive: 1'b1, blink: 1'b0, fen: 1'b0,
                                         ref_lvl: 1'b1, flt: 1'b0};

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes STAGES >= 2; all stages reset to RESET_VAL (idle-high pins).
module gpio_sync #(
    parameter int   WIDTH     = 4,
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= {WIDTH{RESET_VAL}};
        else        stage_q[0] <= d_async;
    end

    // Remaining stages form the shift chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= {WIDTH{RESET_VAL}};
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_blink_gen.sv
// Divides the 50 kHz tick into a shared blink phase.
// Phase toggles after every DIV ticks; starts at 0 ("on" half).
// Assumes DIV >= 2.
module gpio_blink_gen #(
    parameter int DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic phase
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count ticks and flip the phase when the count wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                phase <= ~phase;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpio_pin_slice.sv
// State and control for one pin: drive bit, blink enable, fault enable,
// reference level and latched change fault.
// Assumes pin_lvl is already synchronized to clk.
module gpio_pin_slice
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_lvl,
    input  logic drive_we,
    input  logic drive_d,
    input  logic setup_we,
    input  logic blink_d,
    input  logic fen_d,
    input  logic fault_clr,
    input  logic blink_phase,
    output logic drive_q,
    output logic blink_q,
    output logic fen_q,
    output logic fault_q,
    output logic pull_en
);

    pin_state_t st_q;

    logic fen_rise;
    logic fen_drop;
    logic mismatch;

    assign fen_rise = setup_we &  fen_d & ~st_q.fen;
    assign fen_drop = setup_we & ~fen_d;
    assign mismatch = st_q.fen & (pin_lvl != st_q.ref_lvl);

    // Register updates, reference capture and fault latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PIN_RESET;
        end else begin
            if (drive_we) st_q.drive <= drive_d;
            if (setup_we) begin
                st_q.blink <= blink_d;
                st_q.fen   <= fen_d;
            end
            if (fen_rise || fault_clr) st_q.ref_lvl <= pin_lvl;
            if (fault_clr || fen_drop) st_q.flt <= 1'b0;
            else if (mismatch)         st_q.flt <= 1'b1;
        end
    end

    // Pull-down on when driven low, except in the blink "off" half.
    assign pull_en = ~st_q.drive & ~(st_q.blink & blink_phase);

    assign drive_q = st_q.drive;
    assign blink_q = st_q.blink;
    assign fen_q   = st_q.fen;
    assign fault_q = st_q.flt;

endmodule

// File: rtl/gpio_port_ctl.sv
// General-purpose pin port: synchronizer, shared blink divider and one
// slice per pin. Register read values are assembled from slice state.
// Assumes the write strobes and fault_clr are single-cycle pulses.
module gpio_port_ctl #(
    parameter int NPIN        = 4,
    parameter int BLINK_DIV   = 16384,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_50k,
    input  logic [NPIN-1:0]   pin_in,
    input  logic              data_wr,
    input  logic              setup_wr,
    input  logic [2*NPIN-1:0] wr_data,
    input  logic              fault_clr,
    output logic [NPIN-1:0]   pull_en,
    output logic [2*NPIN-1:0] data_rd,
    output logic [2*NPIN-1:0] setup_rd,
    output logic [NPIN-1:0]   fault
);

    logic [NPIN-1:0] pin_s;
    logic [NPIN-1:0] drive_v;
    logic [NPIN-1:0] blink_v;
    logic [NPIN-1:0] fen_v;
    logic            phase;

    gpio_sync #(
        .WIDTH    (NPIN),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(pin_in),
        .q_sync (pin_s)
    );

    gpio_blink_gen #(
        .DIV(BLINK_DIV)
    ) u_blink (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_50k),
        .phase(phase)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpio_pin_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_lvl    (pin_s[i]),
            .drive_we   (data_wr),
            .drive_d    (wr_data[i]),
            .setup_we   (setup_wr),
            .blink_d    (wr_data[NPIN+i]),
            .fen_d      (wr_data[i]),
            .fault_clr  (fault_clr),
            .blink_phase(phase),
            .drive_q    (drive_v[i]),
            .blink_q    (blink_v[i]),
            .fen_q      (fen_v[i]),
            .fault_q    (fault[i]),
            .pull_en    (pull_en[i])
        );
    end

    assign data_rd  = {pin_s, drive_v};
    assign setup_rd = {blink_v, fen_v};

endmodule

// File: rtl/gpio_port_ctl_chk.sv
// Cycle-by-cycle properties of the pin port, observed at its ports.
// Assumes the default two-stage synchronizer for the readback property.
module gpio_port_ctl_chk #(
    parameter int NPIN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_50k,
    input logic [NPIN-1:0]   pin_in,
    input logic              data_wr,
    input logic              setup_wr,
    input logic [2*NPIN-1:0] wr_data,
    input logic              fault_clr,
    input logic [NPIN-1:0]   pull_en,
    input logic [2*NPIN-1:0] data_rd,
    input logic [2*NPIN-1:0] setup_rd,
    input logic [NPIN-1:0]   fault
);

    logic [1:0] since_rst;

    // Count edges since reset, saturating, to guard the readback window.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2: a released drive bit never pairs with an active pull-down.
    p_released_no_pull_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd[NPIN-1:0] & pull_en) == '0);

    // R2: a data write lands in the drive bits one cycle later.
    p_drive_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> data_rd[NPIN-1:0] == $past(wr_data[NPIN-1:0]));

    // R3: readback trails the pins by two edges.
    p_readback_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> data_rd[2*NPIN-1:NPIN] == $past(pin_in, 2));

    // R4: a setup write lands one cycle later.
    p_setup_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        setup_wr |=> setup_rd == $past(wr_data));

    // R7: a latched fault persists without a clear or a setup write.
    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_clr && !setup_wr) |=> (fault & $past(fault)) == $past(fault));

    // R8, R10: no fault on a pin whose enable is clear.
    p_fault_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault & ~setup_rd[NPIN-1:0]) == '0);

    // R9: a clear strobe empties the fault bits.
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> fault == '0);

    // R5: pull-downs only move on a tick or a register write.
    p_pull_moves_on_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick_50k) && !$past(data_wr) && !$past(setup_wr) && since_rst != 2'd0)
            |-> $stable(pull_en));

endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.NPIN(NPIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_50k (tick_50k),
    .pin_in   (pin_in),
    .data_wr  (data_wr),
    .setup_wr (setup_wr),
    .wr_data  (wr_data),
    .fault_clr(fault_clr),
    .pull_en  (pull_en),
    .data_rd  (data_rd),
    .setup_rd (setup_rd),
    .fault    (fault)
);

// File: tb/gpio_port_ctl_test.sv
`timescale 1ns/100ps
module gpio_port_ctl_test;

    localparam int NPIN = 4;
    localparam int DIV  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_50k = 1'b0;
    logic [3:0]  pin_in = 4'hF;
    logic        data_wr = 1'b0;
    logic        setup_wr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        fault_clr = 1'b0;
    logic [3:0]  pull_en;
    logic [7:0]  data_rd;
    logic [7:0]  setup_rd;
    logic [3:0]  fault;

    int n_total = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    gpio_port_ctl #(.NPIN(NPIN), .BLINK_DIV(DIV), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .tick_50k(tick_50k), .pin_in(pin_in),
        .data_wr(data_wr), .setup_wr(setup_wr), .wr_data(wr_data),
        .fault_clr(fault_clr), .pull_en(pull_en), .data_rd(data_rd),
        .setup_rd(setup_rd), .fault(fault)
    );

    // Vector fields: {write data, pin levels, expected pull_en, expected data_rd}
    localparam logic [23:0] VEC [6] = '{
        {8'h0F, 4'hF, 4'h0, 8'hFF},
        {8'h00, 4'hA, 4'hF, 8'hA0},
        {8'h05, 4'h3, 4'hA, 8'h35},
        {8'hC6, 4'h5, 4'h9, 8'h56},
        {8'h0C, 4'h0, 4'h3, 8'h0C},
        {8'h0F, 4'hF, 4'h0, 8'hFF}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_data_reg(input logic [7:0] v);
        data_wr = 1'b1; wr_data = v; step(1); data_wr = 1'b0;
    endtask

    task automatic wr_setup_reg(input logic [7:0] v);
        setup_wr = 1'b1; wr_data = v; step(1); setup_wr = 1'b0;
    endtask

    task automatic pulse_clear();
        fault_clr = 1'b1; step(1); fault_clr = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        check("R1 data_rd", data_rd, 8'hFF);
        check("R1 setup_rd", setup_rd, 8'h00);
        check("R1 fault", {4'h0, fault}, 8'h00);
        check("R1 pull_en", {4'h0, pull_en}, 8'h00);

        // R2, R3: drive/readback vectors
        foreach (VEC[k]) begin
            pin_in = VEC[k][15:12];
            wr_data_reg(VEC[k][23:16]);
            step(1);
            check("R2 pull_en vector", {4'h0, pull_en}, {4'h0, VEC[k][11:8]});
            check("R3 data_rd vector", data_rd, VEC[k][7:0]);
        end

        // R3: exactly two edges of latency
        pin_in = 4'h6;
        step(1);
        check("R3 after one edge", data_rd, 8'hFF);
        step(1);
        check("R3 after two edges", data_rd, 8'h6F);
        pin_in = 4'hF;
        step(2);

        // R4, R5, R6: blink on pin0 (driven low) and pin1 (released)
        wr_setup_reg(8'h30);
        check("R4 setup readback", setup_rd, 8'h30);
        wr_data_reg(8'h0E);
        check("R5 on half", {4'h0, pull_en}, 8'h01);
        tick_50k = 1'b1;
        step(DIV - 1);
        check("R5 before last tick", {4'h0, pull_en}, 8'h01);
        step(1);
        check("R5 off half", {4'h0, pull_en}, 8'h00);
        step(DIV);
        check("R5 back on", {4'h0, pull_en}, 8'h01);
        check("R6 released pin stays off", {7'h0, pull_en[1]}, 8'h00);
        step(DIV);
        check("R6 released pin off in other half", {7'h0, pull_en[1]}, 8'h00);
        tick_50k = 1'b0;
        wr_data_reg(8'h0F);
        wr_setup_reg(8'h00);

        // R7: enable on pin0, change, return
        wr_setup_reg(8'h01);
        step(3);
        check("R7 no fault at reference", {4'h0, fault}, 8'h00);
        pin_in = 4'hE;
        step(3);
        check("R7 fault on change", {4'h0, fault}, 8'h01);
        pin_in = 4'hF;
        step(3);
        check("R7 fault stays latched", {4'h0, fault}, 8'h01);

        // R9: clear recaptures the level
        pulse_clear();
        check("R9 cleared", {4'h0, fault}, 8'h00);
        step(3);
        check("R9 no refault at same level", {4'h0, fault}, 8'h00);
        pin_in = 4'hE;
        step(3);
        check("R9 refault on move", {4'h0, fault}, 8'h01);
        pulse_clear();
        step(3);
        check("R9 low level is new reference", {4'h0, fault}, 8'h00);
        pin_in = 4'hF;
        step(3);
        check("R9 refault on move back", {4'h0, fault}, 8'h01);

        // R10: dropping the enable clears the fault
        wr_setup_reg(8'h00);
        check("R10 enable drop clears", {4'h0, fault}, 8'h00);

        // R8: changes with every enable clear
        pin_in = 4'h0;
        step(3);
        check("R8 no fault while disabled", {4'h0, fault}, 8'h00);
        pin_in = 4'hF;
        step(3);

        // R7: enable rising captures an already-low level
        pin_in = 4'h7;
        step(3);
        wr_setup_reg(8'h08);
        step(3);
        check("R7 reference taken at enable", {4'h0, fault}, 8'h00);
        wr_setup_reg(8'h00);
        pin_in = 4'hF;
        step(3);

        // R11: clear coincides with the change reaching the comparison
        wr_setup_reg(8'h04);
        step(2);
        pin_in = 4'hB;
        step(2);
        fault_clr = 1'b1;
        step(1);
        fault_clr = 1'b0;
        check("R11 clear wins", {4'h0, fault}, 8'h00);
        step(3);
        check("R11 new level is reference", {4'h0, fault}, 8'h00);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule